// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This controller brings a clock synthesizer up to a target of about 66 MHz when the frequency of the host bus that feeds it is not known in advance. Right after reset it reads a free-running frequency counter word once and checks that the word carries a fixed validity signature. It turns the low bits of the word into a host bus frequency and rounds that figure to one of four nominal bands. From the band it derives a lock window, made of a low and a high bound. It then selects the synthesized clock and turns tuning on.

Next the controller qualifies lock. It samples the lock flag once per poll tick until it first reads set. From that point the flag must stay set on every clock for a fixed run of further samples. A single clear sample ends the attempt as a failure. After a failure the window stays loaded but tuning is switched off, and the controller tries again, up to a bounded number of attempts. When lock qualifies, tuning is switched off and success is reported. Either way, the end is marked by a one-cycle `done` pulse, and `ok` carries the verdict on that same cycle.

Top module: `pll_lock_qualifier`

## Requirements
- R1: The counter word counts as valid only when bits 31:12 equal 20'hABCDE. An invalid word makes the controller assume a 33 MHz host bus.
- R2: For a valid word, the estimate is (word[8:0] * 77) / 192, using integer division. An estimate below 40 rounds to 33 MHz, below 45 to 40 MHz, below 55 to 50 MHz, and anything else to 66 MHz.
- R3: `win_lo` equals (band MHz * 48) / 66, using integer division, and `win_hi` equals `win_lo` + 2. Both hold from the first cycle after the first active clock edge following reset, and they then stay unchanged.
- R4: `fast_bus` is 1 exactly when the band is above 60 MHz, which means only the 66 MHz band.
- R5: During reset, `tune_en`, `clk_sel`, `done` and `ok` are all 0. After reset, `clk_sel` and `tune_en` rise together and stay up through the first attempt.
- R6: In the polling phase of an attempt, the lock flag is sampled only on clocks where `poll_tick` is 1. If POLL_LIMIT samples all read clear, the attempt fails.
- R7: Once the flag has been seen set, it must read set on each of the next HOLD_LIMIT clocks, whatever `poll_tick` does. The first clear sample fails the attempt. With lock held from the first poll sample, `done` appears on the cycle after clock edge HOLD_LIMIT+3, counting from edge 0, the first edge with reset low.
- R8: On a qualified lock, `tune_en` is cleared, and `done` pulses with `ok` = 1.
- R9: After a failed attempt, `tune_en` is cleared and stays cleared for all later attempts. After MAX_TRIES failed attempts, `done` pulses with `ok` = 0.
- R10: `done` is high for exactly one cycle per reset. Afterwards `ok`, the window and `fast_bus` hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new bring-up |
| freq_word | input | 32 | Raw host bus frequency counter word with validity signature |
| lock_flag | input | 1 | Lock indication from the clock synthesizer |
| poll_tick | input | 1 | Enables one lock sample in the polling phase |
| win_lo | output | WIN_W | Lower bound of the lock window |
| win_hi | output | WIN_W | Upper bound of the lock window |
| tune_en | output | 1 | Synthesizer tuning enable |
| clk_sel | output | 1 | 1 selects the synthesized clock |
| done | output | 1 | One-cycle end-of-bring-up pulse |
| ok | output | 1 | 1 when lock qualified; valid with `done` |
| fast_bus | output | 1 | Host bus band is above 60 MHz |

## Verification
The bench builds the controller with POLL_LIMIT=6, HOLD_LIMIT=5 and MAX_TRIES=3. With these values, a complete run that exhausts every retry ends within about 25 cycles, so exact cycle checks become practical. The tests cover lock that is held one sample short of the run and lock that is held exactly long enough. They also cover lock that first appears on the last poll sample, lock that first appears in the second attempt, and polling gated by sparse ticks. Separately, a table of counter words sits on either side of every band edge and includes a bad signature.

// File: rtl/plq_pkg.sv
package plq_pkg;

    localparam logic [19:0] CNT_SIG = 20'hABCDE;
    localparam int          MHZ_W   = 7;

    typedef enum logic [1:0] {
        CT_MEAS,
        CT_RUN,
        CT_END
    } ctl_state_t;

    typedef enum logic [1:0] {
        QP_IDLE,
        QP_POLL,
        QP_HOLD
    } qual_phase_t;

    typedef struct packed {
        logic [MHZ_W-1:0] mhz;
        logic             fast;
    } bus_band_t;

    // Estimate the host bus frequency from the counter word and round it to a band
    function automatic bus_band_t classify(logic [31:0] word);
        logic [15:0] est;
        bus_band_t   b;
        est = ({7'd0, word[8:0]} * 16'd77) / 16'd192;
        if (word[31:12] != CNT_SIG)
            b.mhz = MHZ_W'(33);
        else if (est < 16'd40)
            b.mhz = MHZ_W'(33);
        else if (est < 16'd45)
            b.mhz = MHZ_W'(40);
        else if (est < 16'd55)
            b.mhz = MHZ_W'(50);
        else
            b.mhz = MHZ_W'(66);
        b.fast = (b.mhz > MHZ_W'(60));
        return b;
    endfunction

    // Lower lock-window bound for a given band
    function automatic logic [15:0] win_floor(logic [MHZ_W-1:0] mhz);
        return ({9'd0, mhz} * 16'd48) / 16'd66;
    endfunction

endpackage

// File: rtl/plq_band_est.sv
module plq_band_est
    import plq_pkg::*;
(
    input  logic [31:0] freq_word,
    output bus_band_t   band
);
    always_comb begin
        band = classify(freq_word);
    end
endmodule

// File: rtl/plq_window.sv
module plq_window
    import plq_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [MHZ_W-1:0] mhz,
    output logic [WIN_W-1:0] win_lo,
    output logic [WIN_W-1:0] win_hi
);
    logic [15:0] lo_calc;

    always_comb begin
        lo_calc = win_floor(mhz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_lo <= '0;
            win_hi <= '0;
        end else if (load) begin
            win_lo <= WIN_W'(lo_calc);
            win_hi <= WIN_W'(lo_calc + 16'd2);
        end
    end
endmodule

// File: rtl/plq_qualifier.sv
module plq_qualifier
    import plq_pkg::*;
#(
    parameter int POLL_LIMIT = 20480,
    parameter int HOLD_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic poll_tick,
    input  logic lock_flag,
    output logic pass,
    output logic fail
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam int HCW = $clog2(HOLD_LIMIT + 1);
    localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_LIMIT - 1);
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_LIMIT - 1);

    qual_phase_t    phase;
    logic [PCW-1:0] poll_cnt;
    logic [HCW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= QP_IDLE;
            poll_cnt <= '0;
            hold_cnt <= '0;
            pass     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            pass <= 1'b0;
            fail <= 1'b0;
            case (phase)
                QP_IDLE: begin
                    if (arm) begin
                        phase    <= QP_POLL;
                        poll_cnt <= '0;
                    end
                end
                QP_POLL: begin
                    if (poll_tick) begin
                        if (lock_flag) begin
                            phase    <= QP_HOLD;
                            hold_cnt <= '0;
                        end else if (poll_cnt == POLL_LAST) begin
                            fail  <= 1'b1;
                            phase <= QP_IDLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                QP_HOLD: begin
                    if (!lock_flag) begin
                        fail  <= 1'b1;
                        phase <= QP_IDLE;
                    end else if (hold_cnt == HOLD_LAST) begin
                        pass  <= 1'b1;
                        phase <= QP_IDLE;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: phase <= QP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
    import plq_pkg::*;
#(
    parameter int WIN_W      = 16,
    parameter int POLL_LIMIT = 20480,
    parameter int HOLD_LIMIT = 4096,
    parameter int MAX_TRIES  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      freq_word,
    input  logic             lock_flag,
    input  logic             poll_tick,
    output logic [WIN_W-1:0] win_lo,
    output logic [WIN_W-1:0] win_hi,
    output logic             tune_en,
    output logic             clk_sel,
    output logic             done,
    output logic             ok,
    output logic             fast_bus
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

    ctl_state_t    st;
    logic [TW-1:0] tries;
    logic          arm;
    logic          q_pass;
    logic          q_fail;
    logic          load;
    bus_band_t     band;

    assign load = (st == CT_MEAS);

    plq_band_est u_band (
        .freq_word (freq_word),
        .band      (band)
    );

    plq_window #(.WIN_W(WIN_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .mhz    (band.mhz),
        .win_lo (win_lo),
        .win_hi (win_hi)
    );

    plq_qualifier #(
        .POLL_LIMIT (POLL_LIMIT),
        .HOLD_LIMIT (HOLD_LIMIT)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .poll_tick (poll_tick),
        .lock_flag (lock_flag),
        .pass      (q_pass),
        .fail      (q_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CT_MEAS;
            tries    <= '0;
            arm      <= 1'b0;
            tune_en  <= 1'b0;
            clk_sel  <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
            fast_bus <= 1'b0;
        end else begin
            arm  <= 1'b0;
            done <= 1'b0;
            case (st)
                CT_MEAS: begin
                    tune_en  <= 1'b1;
                    clk_sel  <= 1'b1;
                    fast_bus <= band.fast;
                    arm      <= 1'b1;
                    st       <= CT_RUN;
                end
                CT_RUN: begin
                    if (q_pass) begin
                        tune_en <= 1'b0;
                        done    <= 1'b1;
                        ok      <= 1'b1;
                        st      <= CT_END;
                    end else if (q_fail) begin
                        tune_en <= 1'b0;
                        if (tries == TRY_LAST) begin
                            done <= 1'b1;
                            ok   <= 1'b0;
                            st   <= CT_END;
                        end else begin
                            tries <= tries + 1'b1;
                            arm   <= 1'b1;
                        end
                    end
                end
                default: st <= CT_END;
            endcase
        end
    end
endmodule

// File: rtl/plq_checker.sv
module plq_checker #(
    parameter int WIN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lock_flag,
    input logic [WIN_W-1:0] win_lo,
    input logic             tune_en,
    input logic             clk_sel,
    input logic             done,
    input logic             ok,
    input logic             fast_bus
);
    logic done_seen;

    always_ff @(posedge clk) begin
        if (rst) done_seen <= 1'b0;
        else if (done) done_seen <= 1'b1;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_seen |-> ($stable(ok) && $stable(win_lo) && $stable(fast_bus)));

    // R8
    tune_off_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !tune_en);

    // R9
    tune_stays_off_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel && !tune_en) |=> !tune_en);

    // R5
    tune_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        tune_en |-> clk_sel);

    // R4
    fast_window_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel && fast_bus) |-> (win_lo == WIN_W'(48)));

    // R4
    slow_window_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel && !fast_bus) |-> (win_lo < WIN_W'(48)));

    // R7
    pass_had_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> $past(lock_flag, 2));
endmodule

bind pll_lock_qualifier plq_checker #(.WIN_W(WIN_W)) u_plq_chk (
    .clk       (clk),
    .rst       (rst),
    .lock_flag (lock_flag),
    .win_lo    (win_lo),
    .tune_en   (tune_en),
    .clk_sel   (clk_sel),
    .done      (done),
    .ok        (ok),
    .fast_bus  (fast_bus)
);

// File: tb/tb_pll_lock_qualifier.sv
module tb_pll_lock_qualifier;

    localparam int WIN_W = 16;
    localparam int P = 6;
    localparam int H = 5;
    localparam int T = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [31:0]      freq_word = '0;
    logic             lock_flag = 1'b0;
    logic             poll_tick = 1'b0;
    logic [WIN_W-1:0] win_lo, win_hi;
    logic             tune_en, clk_sel, done, ok, fast_bus;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int prof = 0;

    pll_lock_qualifier #(
        .WIN_W (WIN_W), .POLL_LIMIT (P), .HOLD_LIMIT (H), .MAX_TRIES (T)
    ) dut (
        .clk (clk), .rst (rst), .freq_word (freq_word),
        .lock_flag (lock_flag), .poll_tick (poll_tick),
        .win_lo (win_lo), .win_hi (win_hi), .tune_en (tune_en),
        .clk_sel (clk_sel), .done (done), .ok (ok), .fast_bus (fast_bus)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Lock profile: value sampled at clock edge k (edge 0 = first edge with reset low)
    function automatic logic lock_of(input int p, input int k);
        case (p)
            0: return 1'b1;                 // steady lock
            1: return (k >= 2 && k <= 6);   // held one sample short
            2: return (k >= 2 && k <= 7);   // held exactly long enough
            3: return 1'b0;                 // never locks
            4: return (k >= 12);            // locks during second attempt
            5: return 1'b1;                 // steady, sparse ticks
            6: return (k >= 7);             // appears on last poll sample
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic tick_of(input int p, input int k);
        if (p == 5) return (k % 3 == 0);
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        lock_flag = lock_of(prof, cyc);
        poll_tick = tick_of(prof, cyc);
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // {word, expected win_lo, expected win_hi, expected fast_bus}
    localparam logic [64:0] VEC [10] = '{
        {32'hABCDE063, 16'd24, 16'd26, 1'b0},
        {32'hABCDE064, 16'd29, 16'd31, 1'b0},
        {32'hABCDE070, 16'd29, 16'd31, 1'b0},
        {32'hABCDE071, 16'd36, 16'd38, 1'b0},
        {32'hABCDE089, 16'd36, 16'd38, 1'b0},
        {32'hABCDE08A, 16'd48, 16'd50, 1'b1},
        {32'hABCDE1FF, 16'd48, 16'd50, 1'b1},
        {32'hABCDF1FF, 16'd24, 16'd26, 1'b0},
        {32'hABCDEE64, 16'd29, 16'd31, 1'b0},
        {32'hABCDE000, 16'd24, 16'd26, 1'b0}
    };

    task automatic run_case(input logic [31:0] w, input int p,
                            input int exp_lo, input int exp_hi, input int exp_fast,
                            input int exp_cyc, input int exp_ok, input string tag);
        bit seen;
        @(negedge clk);
        rst = 1'b1;
        freq_word = w;
        prof = p;
        repeat (2) @(negedge clk);
        chk(!done && !ok && !tune_en && !clk_sel, "R5", {tag, " reset outputs"},
            int'({done, ok, tune_en, clk_sel}), 0);
        rst = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (cyc == 2) begin
                chk(int'(win_lo) == exp_lo, "R1 R2 R3", {tag, " win_lo"}, int'(win_lo), exp_lo);
                chk(int'(win_hi) == exp_hi, "R3", {tag, " win_hi"}, int'(win_hi), exp_hi);
                chk(int'(fast_bus) == exp_fast, "R4", {tag, " fast_bus"}, int'(fast_bus), exp_fast);
                chk(clk_sel && tune_en, "R5", {tag, " sel and tune"}, int'({clk_sel, tune_en}), 3);
            end
            if (p == 3 && cyc == 7)
                chk(tune_en == 1'b1, "R5", {tag, " tune during attempt 1"}, int'(tune_en), 1);
            if ((p == 3 || p == 4) && cyc == 12)
                chk(tune_en == 1'b0, "R9", {tag, " tune after failure"}, int'(tune_en), 0);
            if (done) begin
                seen = 1'b1;
                chk(cyc == exp_cyc, "R6 R7", {tag, " done cycle"}, cyc, exp_cyc);
                chk(int'(ok) == exp_ok, exp_ok ? "R8" : "R9", {tag, " ok"}, int'(ok), exp_ok);
                chk(tune_en == 1'b0, "R8", {tag, " tune at end"}, int'(tune_en), 0);
            end
        end
        if (!seen) chk(1'b0, "R10", {tag, " done never seen"}, 0, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10", {tag, " done width"}, int'(done), 0);
        chk(int'(ok) == exp_ok, "R10", {tag, " ok held"}, int'(ok), exp_ok);
        chk(int'(win_lo) == exp_lo, "R10", {tag, " window held"}, int'(win_lo), exp_lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Band and window table (R1, R2, R3, R4), steady lock
        for (int i = 0; i < 10; i++) begin
            run_case(VEC[i][64:33], 0, int'(VEC[i][32:17]), int'(VEC[i][16:1]),
                     int'(VEC[i][0]), H + 4, 1, $sformatf("vec%0d", i));
        end
        // R7: lock held for only H samples fails every try
        run_case(32'hABCDE1FF, 1, 48, 50, 1, 25, 0, "short_hold");
        // R7: lock held for H+1 samples passes
        run_case(32'hABCDE1FF, 2, 48, 50, 1, 9, 1, "exact_hold");
        // R6 R9: never locks, retries exhausted
        run_case(32'hABCDE064, 3, 29, 31, 0, 25, 0, "no_lock");
        // R9 R8: locks on second attempt with tuning off
        run_case(32'hABCDE089, 4, 36, 38, 0, 19, 1, "second_try");
        // R6: sparse poll ticks
        run_case(32'hABCDE063, 5, 24, 26, 0, 10, 1, "sparse_tick");
        // R6: lock first seen on last poll sample
        run_case(32'hABCDF000, 6, 24, 26, 0, 14, 1, "last_poll");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule